// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is a bus-attached watchdog timer. Once software sets its enable bit, the input clock is divided by a fixed factor of 32. The divided ticks then drive a counter whose period is two to the power of a configured postscale value. Before the counter reaches the end of its period, software must write a 16-bit magic key to the upper half-word of the control register. If it does not, the block issues a one-cycle reset request, starts a new period and records the event in a sticky status register.

The postscale value, the clock-source select code and the window-mode bit are fixed by configuration, in the way fuse settings would be. They are visible in the control register but cannot be written from the bus. When window mode is on, a key that arrives before the last quarter of the period counts as a fault and raises the reset request at once. Enable and the status flags can be written directly, through a set alias (ones set bits) or through a clear alias (ones clear bits). For one cycle after the enable bit drops, the bus interface stalls and accepts nothing.

Top module: `kwdt_top`

## Requirements
- R1: After reset the enable bit is 0, the status register reads 0, `wdtResetReq` is 0 and `busReady` is 1.
- R2: A word read of byte offset 0x00 returns the enable bit in bit 15, the postscale value in bits 12:8, the clock-select code in bits 7:6 and the window bit in bit 0. All other bits read 0.
- R3: A word write changes the enable bit in one of three ways. At 0x00 it loads bit 15 of the data. At the set alias 0x08, a 1 in bit 15 sets it. At the clear alias 0x04, a 1 in bit 15 clears it. No write changes the postscale, clock-select or window fields.
- R4: When enabled with postscale value `ps`, the reset request rises exactly 32 × 2^ps clock cycles after the clock edge that enabled the timer or last restarted it.
- R5: A half-word write (`busHalf`=1) to byte offset 0x02 with `busWdata[31:15+1]` equal to 0x5743 restarts both the prescaler and the counter while the timer is enabled.
- R6: A half-word write of any other value to 0x02 has no effect on the counter. Neither does a word write to 0x00 whose upper half holds 0x5743.
- R7: On expiry `wdtResetReq` is high for exactly one cycle. In the same cycle, bit 4 of the status register (byte offset 0x10) reads 1. The next period starts right away, so the next expiry follows 32 × 2^ps cycles later.
- R8: On any expiry or window fault, status bit 3 captures `sleepMode` and bit 2 captures `idleMode`. A write to 0x10 loads bits 4:2. Ones written to the set alias 0x18 set status bits. Ones written to the clear alias 0x14 clear them.
- R9: With window mode on, a valid key written while the counter is below 3/4 of the terminal count raises `wdtResetReq` and status bit 4 on that same clock edge. A valid key written at or after that point is a legal restart.
- R10: In the cycle after the enable bit goes from 1 to 0, `busReady` is 0 and any write in that cycle is ignored.
- R11: While disabled, the counter is held, no reset request is raised and the key is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busHalf | input | 1 | 1 = half-word write, 0 = word |
| busAddr | input | 5 | Byte offset |
| busWdata | input | 32 | Write data (half-word at offset 2 uses bits 31:16) |
| busRdata | output | 32 | Read data, combinational on a read |
| busReady | output | 1 | 0 while the post-disable stall is active |
| cfgPostscale | input | 5 | Static postscale exponent |
| cfgClkSel | input | 2 | Static clock-select code (read back only) |
| cfgWindow | input | 1 | Static window-mode enable |
| idleMode | input | 1 | System idle indicator, captured on expiry |
| sleepMode | input | 1 | System sleep indicator, captured on expiry |
| wdtResetReq | output | 1 | One-cycle reset request |

## Verification
Writes take effect at the clock edge that captures them. The enable bit, the status bits and the stall are therefore checked at the falling edge right after that capture edge. Reads are combinational and are sampled a moment after the address is driven. An expiry comes 32 × 2^ps edges after the edge that enabled or restarted the timer. The bench counts falling edges from the end of that write until the reset request appears, and compares the count with 128 for ps = 2, or 127 when a write of one more cycle lies in between. A window fault shows up on the key's own capture edge, so the request is checked at the falling edge straight after the write.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  // byte offsets (the key half-word at 2 and control at 0 are fixed by behaviour)
  localparam int CTRL_OFS = 0;
  localparam int KEY_OFS  = 2;
  localparam int CTRL_CLR = 4;
  localparam int CTRL_SET = 8;
  localparam int STAT_OFS = 16;
  localparam int STAT_CLR = 20;
  localparam int STAT_SET = 24;

  // control field positions
  localparam int EN_BIT  = 15;
  localparam int PS_LSB  = 8;
  localparam int CS_LSB  = 6;
  localparam int WIN_BIT = 0;

  // status field positions
  localparam int ST_TO    = 4;
  localparam int ST_SLEEP = 3;
  localparam int ST_IDLE  = 2;

  typedef struct packed {
    logic enable;
    logic keyHit;
  } wdStrobe_t;
endpackage

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int PS_W   = 5,
  parameter int CS_W   = 2,
  parameter int KEY_W  = 16,
  parameter logic [KEY_W-1:0] KEY = 16'h5743
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic              busHalf,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady,
  input  logic [PS_W-1:0]   cfgPostscale,
  input  logic [CS_W-1:0]   cfgClkSel,
  input  logic              cfgWindow,
  input  logic              idleMode,
  input  logic              sleepMode,
  input  logic              fire,
  output wdStrobe_t         strobe,
  output logic              timeoutFlag
);
  localparam int KEY_LSB = DATA_W - KEY_W;

  logic       enQ, enNext;
  logic       busyQ;
  logic [2:0] statQ, statNext;   // [2]=timeout [1]=sleep [0]=idle
  logic       accept, wordWr;

  assign accept = busSel && busWrite && !busyQ;
  assign wordWr = accept && !busHalf;

  always_comb begin
    enNext = enQ;
    if (wordWr) begin
      if (busAddr == ADDR_W'(CTRL_OFS))                          enNext = busWdata[EN_BIT];
      else if (busAddr == ADDR_W'(CTRL_SET) && busWdata[EN_BIT]) enNext = 1'b1;
      else if (busAddr == ADDR_W'(CTRL_CLR) && busWdata[EN_BIT]) enNext = 1'b0;
    end
  end

  always_comb begin
    statNext = statQ;
    if (wordWr) begin
      if (busAddr == ADDR_W'(STAT_OFS))
        statNext = busWdata[ST_TO:ST_IDLE];
      else if (busAddr == ADDR_W'(STAT_SET))
        statNext = statQ | busWdata[ST_TO:ST_IDLE];
      else if (busAddr == ADDR_W'(STAT_CLR))
        statNext = statQ & ~busWdata[ST_TO:ST_IDLE];
    end
    if (fire) statNext = {1'b1, sleepMode, idleMode};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      busyQ <= 1'b0;
      statQ <= '0;
    end else begin
      enQ   <= enNext;
      busyQ <= enQ && !enNext;
      statQ <= statNext;
    end
  end

  assign strobe.enable = enQ;
  assign strobe.keyHit = accept && busHalf && enQ &&
                         (busAddr == ADDR_W'(KEY_OFS)) &&
                         (busWdata[DATA_W-1:KEY_LSB] == KEY);

  always_comb begin
    busRdata = '0;
    if (busSel && !busWrite) begin
      if (busAddr == ADDR_W'(CTRL_OFS)) begin
        busRdata[EN_BIT]                = enQ;
        busRdata[PS_LSB +: PS_W]        = cfgPostscale;
        busRdata[CS_LSB +: CS_W]        = cfgClkSel;
        busRdata[WIN_BIT]               = cfgWindow;
      end else if (busAddr == ADDR_W'(STAT_OFS)) begin
        busRdata[ST_TO:ST_IDLE]         = statQ;
      end
    end
  end

  assign busReady    = !busyQ;
  assign timeoutFlag = statQ[2];
endmodule

// File: rtl/kwdt_datapath.sv
module kwdt_datapath
  import kwdt_pkg::*;
#(
  parameter int PS_W     = 5,
  parameter int PRE_LOG2 = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  wdStrobe_t       strobe,
  input  logic [PS_W-1:0] cfgPostscale,
  input  logic            cfgWindow,
  output logic            fire,
  output logic            rstReq
);
  localparam int CNT_W = 1 << PS_W;

  logic [PRE_LOG2-1:0] preQ;
  logic [CNT_W-1:0]    cntQ;
  logic [CNT_W-1:0]    termSpan, termLast, winStart;
  logic                tick, expire, early;

  assign termSpan = CNT_W'(1) << cfgPostscale;
  assign termLast = termSpan - CNT_W'(1);
  assign winStart = termSpan - (termSpan >> 2);

  assign tick   = strobe.enable && (preQ == '1);
  assign expire = tick && (cntQ == termLast);
  assign early  = strobe.keyHit && cfgWindow && (cntQ < winStart);
  assign fire   = expire || early;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preQ   <= '0;
      cntQ   <= '0;
      rstReq <= 1'b0;
    end else begin
      rstReq <= fire;
      if (!strobe.enable || strobe.keyHit) begin
        preQ <= '0;
        cntQ <= '0;
      end else begin
        preQ <= preQ + PRE_LOG2'(1);
        if (tick) cntQ <= expire ? '0 : cntQ + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int PS_W     = 5,
  parameter int CS_W     = 2,
  parameter int PRE_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic              busHalf,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady,
  input  logic [PS_W-1:0]   cfgPostscale,
  input  logic [CS_W-1:0]   cfgClkSel,
  input  logic              cfgWindow,
  input  logic              idleMode,
  input  logic              sleepMode,
  output logic              wdtResetReq
);
  wdStrobe_t strobe;
  logic      fire;
  logic      timeoutFlag;
  logic      enLevel;

  assign enLevel = strobe.enable;

  kwdt_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PS_W(PS_W), .CS_W(CS_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWrite(busWrite), .busHalf(busHalf),
    .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busReady(busReady),
    .cfgPostscale(cfgPostscale), .cfgClkSel(cfgClkSel), .cfgWindow(cfgWindow),
    .idleMode(idleMode), .sleepMode(sleepMode),
    .fire(fire), .strobe(strobe), .timeoutFlag(timeoutFlag)
  );

  kwdt_datapath #(
    .PS_W(PS_W), .PRE_LOG2(PRE_LOG2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgPostscale(cfgPostscale), .cfgWindow(cfgWindow),
    .fire(fire), .rstReq(wdtResetReq)
  );
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk (
  input logic clk,
  input logic rstN,
  input logic rstReq,
  input logic enable,
  input logic timeoutFlag,
  input logic busReady
);
  // R7
  flag_with_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> timeoutFlag);

  // R11
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> $past(enable));

  // R10
  stall_after_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enable) |-> !busReady);

  // R10
  stall_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busReady |=> busReady);
endmodule

bind kwdt_top kwdt_chk u_chk (
  .clk(clk), .rstN(rstN), .rstReq(wdtResetReq), .enable(enLevel),
  .timeoutFlag(timeoutFlag), .busReady(busReady)
);

// File: tb/kwdt_top_test.sv
module kwdt_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN, busSel, busWrite, busHalf;
  logic [4:0]  busAddr;
  logic [31:0] busWdata, busRdata;
  logic        busReady, cfgWindow, idleMode, sleepMode, wdtResetReq;
  logic [4:0]  cfgPostscale;
  logic [1:0]  cfgClkSel;

  int testCount = 0;
  int failCount = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kwdt_top uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busHalf(busHalf), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busReady(busReady), .cfgPostscale(cfgPostscale),
    .cfgClkSel(cfgClkSel), .cfgWindow(cfgWindow), .idleMode(idleMode),
    .sleepMode(sleepMode), .wdtResetReq(wdtResetReq)
  );

  typedef struct packed {
    logic [4:0]  wAddr;
    logic        wHalf;
    logic [31:0] wData;
    logic [4:0]  rAddr;
    logic [31:0] expect_;
  } vec_t;

  // ps=2, clksel=1, window=0 -> static part 0x0240
  localparam vec_t VECS [8] = '{
    '{5'd8,  1'b0, 32'h0000_8000, 5'd0,  32'h0000_8240}, // R3 set alias
    '{5'd4,  1'b0, 32'h0000_8000, 5'd0,  32'h0000_0240}, // R3 clr alias
    '{5'd0,  1'b0, 32'hFFFF_FFFF, 5'd0,  32'h0000_8240}, // R3 fields read-only
    '{5'd0,  1'b0, 32'h0000_0000, 5'd0,  32'h0000_0240}, // R3 direct clear
    '{5'd24, 1'b0, 32'h0000_001C, 5'd16, 32'h0000_001C}, // R8 status set
    '{5'd20, 1'b0, 32'h0000_0004, 5'd16, 32'h0000_0018}, // R8 status clr
    '{5'd16, 1'b0, 32'h0000_0000, 5'd16, 32'h0000_0000}, // R8 status load
    '{5'd8,  1'b0, 32'h0000_7FFF, 5'd0,  32'h0000_0240}  // R3 set without bit 15
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [4:0] a, input logic h, input logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busHalf = h; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busHalf = 1'b0;
  endtask

  task automatic busRd(input logic [4:0] a, output logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic waitReq(output int n);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      n++;
      if (wdtResetReq) break;
    end
  endtask

  task automatic disableWdt();
    busWr(5'd4, 1'b0, 32'h0000_8000);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int n;
    bit seen;
    rstN = 1'b0; busSel = 0; busWrite = 0; busHalf = 0; busAddr = '0; busWdata = '0;
    cfgPostscale = 5'd2; cfgClkSel = 2'd1; cfgWindow = 1'b0;
    idleMode = 1'b0; sleepMode = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 layout
    busRd(5'd0, rd);  check("R1/R2 ctrl after reset", rd, 32'h0000_0240);
    busRd(5'd16, rd); check("R1 status after reset", rd, 32'h0);
    check("R1 reset request idle", {31'b0, wdtResetReq}, 32'h0);
    check("R1 ready after reset", {31'b0, busReady}, 32'h1);

    foreach (VECS[i]) begin
      busWr(VECS[i].wAddr, VECS[i].wHalf, VECS[i].wData);
      busRd(VECS[i].rAddr, rd);
      check($sformatf("R3/R8 vector %0d", i), rd, VECS[i].expect_);
      @(negedge clk);
    end

    // R4 timeout length, R7 pulse and flag
    busWr(5'd8, 1'b0, 32'h0000_8000);
    waitReq(n);
    check("R4 cycles to expiry", n, 128);
    busRd(5'd16, rd); check("R7 flag with request", rd, 32'h10);
    @(negedge clk);
    check("R7 pulse one cycle", {31'b0, wdtResetReq}, 32'h0);
    waitReq(n);
    check("R7 reload period", n, 127);

    // R10 stall after disable
    busWr(5'd4, 1'b0, 32'h0000_8000);
    check("R10 ready low after disable", {31'b0, busReady}, 32'h0);
    busWr(5'd8, 1'b0, 32'h0000_8000);
    busRd(5'd0, rd); check("R10 write ignored while stalled", rd, 32'h0000_0240);
    check("R10 ready back", {31'b0, busReady}, 32'h1);
    busWr(5'd20, 1'b0, 32'h0000_001C);

    // R11 disabled: no request, key ignored
    busWr(5'd2, 1'b1, 32'h5743_0000);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (wdtResetReq) seen = 1;
    end
    check("R11 no request while disabled", {31'b0, seen}, 32'h0);
    busRd(5'd16, rd); check("R11 status untouched", rd, 32'h0);

    // R5 key restart
    busWr(5'd8, 1'b0, 32'h0000_8000);
    seen = 0;
    for (int i = 0; i < 99; i++) begin
      @(negedge clk);
      if (wdtResetReq) seen = 1;
    end
    busWr(5'd2, 1'b1, 32'h5743_0000);
    check("R5 no early request", {31'b0, seen | wdtResetReq}, 32'h0);
    waitReq(n);
    check("R5 restart from key", n, 128);
    disableWdt();

    // R6 wrong key and word write ignored
    busWr(5'd8, 1'b0, 32'h0000_8000);
    busWr(5'd2, 1'b1, 32'h1234_0000);
    waitReq(n);
    check("R6 wrong key ignored", n, 127);
    disableWdt();
    busWr(5'd8, 1'b0, 32'h0000_8000);
    busWr(5'd0, 1'b0, 32'h5743_8000);
    waitReq(n);
    check("R6 word write not a key", n, 127);
    disableWdt();

    // R8 sleep capture
    busWr(5'd20, 1'b0, 32'h0000_001C);
    sleepMode = 1'b1;
    busWr(5'd8, 1'b0, 32'h0000_8000);
    waitReq(n);
    busRd(5'd16, rd); check("R8 sleep captured", rd, 32'h18);
    disableWdt();
    sleepMode = 1'b0;
    busWr(5'd20, 1'b0, 32'h0000_001C);
    busRd(5'd16, rd); check("R8 clear alias", rd, 32'h0);

    // R9 window mode
    cfgWindow = 1'b1;
    busRd(5'd0, rd); check("R2 window bit", rd, 32'h0000_0241);
    busWr(5'd8, 1'b0, 32'h0000_8000);
    busWr(5'd2, 1'b1, 32'h5743_0000);
    check("R9 early key faults", {31'b0, wdtResetReq}, 32'h1);
    busRd(5'd16, rd); check("R9 fault sets flag", rd, 32'h10);
    disableWdt();
    busWr(5'd8, 1'b0, 32'h0000_8000);
    repeat (99) @(negedge clk);
    busWr(5'd2, 1'b1, 32'h5743_0000);
    check("R9 late key legal", {31'b0, wdtResetReq}, 32'h0);
    waitReq(n);
    check("R9 late key restarts", n, 128);
    disableWdt();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule